// File: doc/BRIEF.md
# Sampling ADC Digital-Side Emulator

This block is a synthesizable stand-in for the digital face of a 16-bit successive-approximation converter. A host testbench or an FPGA loopback drives it exactly as it would drive the real converter: an active-low start strobe, an active-low select and read pair, a power-down level, a coding select and a parallel sample word that plays the part of the analog input. The block answers with a busy flag and a 16-bit data bus with its own output-enable. Conversion and acquisition times are counted in clock cycles.

The controller is a four-state machine. READY waits for a start edge. CONVERT runs for a fixed count and cannot be cut short. AUTO_ACQ is the internal acquisition phase taken when the start strobe is still low as a conversion ends. SLEEP holds while power-down is high. The transitions are: READY→CONVERT on a start falling edge; READY→SLEEP on power-down; CONVERT→SLEEP, CONVERT→AUTO_ACQ or CONVERT→READY when the count expires, in that order of priority; AUTO_ACQ→CONVERT when its count expires with start still low; AUTO_ACQ→READY when start returns high; AUTO_ACQ→SLEEP on power-down; SLEEP→READY when power-down drops. The sample word is captured when a conversion begins. The coded result reaches the bus only when that conversion ends.

Top module: `sadc_emu`

## Requirements
- R1: After reset, busy is low, the stored result is zero, and the controller is in READY.
- R2: While the controller is in READY, a clock edge that sees start low, when the previous edge saw it high, raises busy from the next cycle. Busy then stays high for exactly CONV_CYC cycles (default 8).
- R3: The sample word is captured on the edge that raises busy. Later changes to the sample input do not affect that conversion's result.
- R4: While busy is high, the bus shows the previous result. The new result is on the bus in the first cycle in which busy is low.
- R5: Further start falling edges during a conversion do not change its length. If start is high when the conversion ends, no new conversion follows.
- R6: Power-down asserted during a conversion does not shorten it, and its result is still published. Once busy falls, the block sleeps, and start edges are ignored while power-down is high. When power-down drops, a fresh start edge starts a conversion. At the end of a conversion, power-down takes priority over automatic restart.
- R7: If start is low when a conversion ends, busy stays low for exactly ACQ_CYC cycles (default 4) and then rises again without any new edge. That next conversion captures the sample present on the edge that raises busy.
- R8: If start returns high during the automatic acquisition phase, no further conversion is launched.
- R9: Holding start low through reset and afterwards does not start a conversion, because an edge is required.
- R10: bus_oe is 1 only when cs_n and rd_n are both 0. Whenever bus_oe is 0, bus_out is all zeros.
- R11: With twos_sel = 0, bus_out is the straight-binary result. With twos_sel = 1, bus_out is the result with bit 15 inverted (two's complement).
- R12: In READY, power-down that is high on the same edge as a start falling edge wins: the block enters SLEEP and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_n | input | 1 | Active-low convert start |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| pwrdn | input | 1 | Power-down request, active high |
| twos_sel | input | 1 | 1 selects two's complement, 0 selects straight binary |
| sample_in | input | 16 | Word standing in for the analog input |
| busy | output | 1 | High while a conversion runs |
| bus_out | output | 16 | Result data, zero when not enabled |
| bus_oe | output | 1 | Output enable for the data bus |

## Verification
The hardest case to reach is the automatic restart, and in particular proving that the second conversion captures the sample present on its own launch edge and not an earlier one. The stimulus holds start low through the end of a conversion. It changes the sample word while busy is low in the acquisition gap, and changes it again as soon as busy rises, so each capture point yields a different value. Power-down is also raised partway through a conversion, and start edges are toggled inside a conversion while start is returned high before the count ends, so the non-abort path is exercised without triggering a restart.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_CONV  = 2'd1,
        ST_ACQ   = 2'd2,
        ST_SLEEP = 2'd3
    } sadc_state_e;

    // Convert a unipolar straight-binary word to the selected output coding.
    function automatic logic [15:0] apply_coding(input logic [15:0] word, input logic twos);
        apply_coding = word ^ {twos, 15'b0};
    endfunction

endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
    import sadc_pkg::*;
#(
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n,
    input  logic pwrdn,
    output logic busy,
    output logic capture,
    output logic publish
);

    localparam int CNT_MAX = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);

    sadc_state_e      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             cnv_q;
    logic             start_fall;

    assign start_fall = cnv_q & ~cnv_n;

    // State register, counter and start edge detector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
            cnv_q <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            cnv_q <= cnv_n;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        capture   = 1'b0;
        publish   = 1'b0;
        unique case (state)
            ST_READY: begin
                if (pwrdn) begin
                    state_nxt = ST_SLEEP;
                end else if (start_fall) begin
                    state_nxt = ST_CONV;
                    cnt_nxt   = CONV_LAST;
                    capture   = 1'b1;
                end
            end
            ST_CONV: begin
                if (cnt == '0) begin
                    publish = 1'b1;
                    if (pwrdn) begin
                        state_nxt = ST_SLEEP;
                    end else if (!cnv_n) begin
                        state_nxt = ST_ACQ;
                        cnt_nxt   = ACQ_LAST;
                    end else begin
                        state_nxt = ST_READY;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_ACQ: begin
                if (pwrdn) begin
                    state_nxt = ST_SLEEP;
                end else if (cnv_n) begin
                    state_nxt = ST_READY;
                end else if (cnt == '0) begin
                    state_nxt = ST_CONV;
                    cnt_nxt   = CONV_LAST;
                    capture   = 1'b1;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!pwrdn) state_nxt = ST_READY;
            end
            default: state_nxt = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state == ST_CONV);
    end

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && cnt != '0) |=> (state == ST_CONV)); // R6

    AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == ST_READY || $past(state) == ST_ACQ)); // R2

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && pwrdn) |=> (state == ST_SLEEP)); // R6

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> (cnt <= CONV_LAST)); // R2

endmodule

// File: rtl/sadc_result.sv
module sadc_result #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              publish,
    input  logic              busy,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] smp_q;
    logic [DATA_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            res_q <= '0;
        end else begin
            if (capture) smp_q <= sample_in;
            if (publish) res_q <= smp_q;
        end
    end

    assign result = res_q;

    AST_HOLD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(res_q)); // R4

endmodule

// File: rtl/sadc_bus.sv
module sadc_bus
    import sadc_pkg::*;
(
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        twos_sel,
    input  logic [15:0] result,
    output logic [15:0] bus_out,
    output logic        bus_oe
);

    always_comb begin
        bus_oe  = ~(cs_n | rd_n);
        bus_out = bus_oe ? apply_coding(result, twos_sel) : 16'h0000;
    end

endmodule

// File: rtl/sadc_emu.sv
module sadc_emu
    import sadc_pkg::*;
#(
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnv_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        pwrdn,
    input  logic        twos_sel,
    input  logic [15:0] sample_in,
    output logic        busy,
    output logic [15:0] bus_out,
    output logic        bus_oe
);

    logic        capture;
    logic        publish;
    logic [15:0] result;

    sadc_ctrl #(
        .CONV_CYC(CONV_CYC),
        .ACQ_CYC (ACQ_CYC)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnv_n  (cnv_n),
        .pwrdn  (pwrdn),
        .busy   (busy),
        .capture(capture),
        .publish(publish)
    );

    sadc_result #(
        .DATA_W(16)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .publish  (publish),
        .busy     (busy),
        .sample_in(sample_in),
        .result   (result)
    );

    sadc_bus u_bus (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .twos_sel(twos_sel),
        .result  (result),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!bus_oe && bus_out == 16'h0000)); // R10

    AST_CODING_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $stable(twos_sel) && $stable(cs_n) && $stable(rd_n) && $past(busy) && busy)
        |-> $stable(bus_out)); // R4

endmodule

// File: tb/sadc_emu_bench.sv
module sadc_emu_bench;

    localparam int CONV_CYC = 8;
    localparam int ACQ_CYC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_n = 1'b0;
    logic        cs_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        pwrdn = 1'b0;
    logic        twos_sel = 1'b0;
    logic [15:0] sample_in = 16'h0000;
    logic        busy;
    logic [15:0] bus_out;
    logic        bus_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sadc_emu #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_sadc_emu (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cs_n(cs_n), .rd_n(rd_n),
        .pwrdn(pwrdn), .twos_sel(twos_sel), .sample_in(sample_in),
        .busy(busy), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Counts negedges with busy high; call right after busy was driven to rise.
    task automatic count_busy(output int n);
        n = 0;
        @(negedge clk);
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] code(input logic [15:0] v, input logic t);
        return t ? (v ^ 16'h8000) : v;
    endfunction

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        // R9: start held low through reset, no edge
        cnv_n = 1'b0;
        rst_n = 1'b0;
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(1);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(bus_out == 16'h0000, "R1 result after reset", bus_out, 0);
        idle_cycles(5);
        check(busy == 1'b0, "R9 no start without edge", busy, 0);
        twos_sel = 1'b1;
        #1;
        check(bus_out == 16'h8000, "R11 zero in twos", bus_out, 16'h8000);
        twos_sel = 1'b0;
        cnv_n = 1'b1;
        idle_cycles(2);
    endtask

    task automatic t_basic(input logic [15:0] v, input logic [15:0] prev);
        int n;
        sample_in = v;
        cnv_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy rises", busy, 1);
        cnv_n = 1'b1;
        sample_in = ~v;   // R3: must not be captured
        check(bus_out == prev, "R4 old result during conv", bus_out, prev);
        count_busy(n);
        check(n == CONV_CYC - 1, "R2 busy length", n + 1, CONV_CYC);
        check(bus_out == v, "R3 R4 new result at busy fall", bus_out, v);
        idle_cycles(ACQ_CYC + 3);
        check(busy == 1'b0, "R5 no restart when start high", busy, 0);
    endtask

    task automatic t_coding_oe(input logic [15:0] v);
        twos_sel = 1'b1;
        #1;
        check(bus_out == code(v, 1'b1), "R11 twos coding", bus_out, code(v, 1'b1));
        twos_sel = 1'b0;
        #1;
        check(bus_out == v, "R11 binary coding", bus_out, v);
        cs_n = 1'b1;
        #1;
        check(bus_oe == 1'b0 && bus_out == 16'h0000, "R10 cs high", bus_out, 0);
        cs_n = 1'b0; rd_n = 1'b1;
        #1;
        check(bus_oe == 1'b0 && bus_out == 16'h0000, "R10 rd high", bus_out, 0);
        rd_n = 1'b0;
        #1;
        check(bus_oe == 1'b1, "R10 both low", bus_oe, 1);
        @(negedge clk);
    endtask

    task automatic t_extra_edges(input logic [15:0] v);
        int n;
        sample_in = v;
        cnv_n = 1'b0;
        @(negedge clk);
        n = 1;
        cnv_n = 1'b1; @(negedge clk); n++;
        cnv_n = 1'b0; @(negedge clk); n++;
        cnv_n = 1'b1;
        while (busy && n < 100) begin @(negedge clk); if (busy) n++; end
        check(n == CONV_CYC, "R5 length with extra edges", n, CONV_CYC);
        idle_cycles(ACQ_CYC + 3);
        check(busy == 1'b0, "R5 no extra conversion", busy, 0);
        check(bus_out == v, "R5 result", bus_out, v);
    endtask

    task automatic t_powerdown(input logic [15:0] v);
        int n;
        sample_in = v;
        cnv_n = 1'b0;
        @(negedge clk);
        idle_cycles(2);
        pwrdn = 1'b1;       // start still low: power-down must win over auto restart
        n = 3;
        while (busy && n < 100) begin @(negedge clk); if (busy) n++; end
        check(n == CONV_CYC, "R6 conv not aborted", n, CONV_CYC);
        check(bus_out == v, "R6 result published", bus_out, v);
        idle_cycles(ACQ_CYC + 3);
        check(busy == 1'b0, "R6 sleep beats auto restart", busy, 0);
        cnv_n = 1'b1; @(negedge clk);
        cnv_n = 1'b0; @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R6 start ignored in sleep", busy, 0);
        pwrdn = 1'b0;
        idle_cycles(2);
        check(busy == 1'b0, "R6 wake needs edge", busy, 0);
        cnv_n = 1'b1; @(negedge clk);
        cnv_n = 1'b0; @(negedge clk);
        check(busy == 1'b1, "R6 start after wake", busy, 1);
        cnv_n = 1'b1;
        count_busy(n);
    endtask

    task automatic t_auto(input logic [15:0] a, input logic [15:0] b);
        int n;
        sample_in = a;
        cnv_n = 1'b0;
        @(negedge clk);
        count_busy(n);
        check(bus_out == a, "R7 first result", bus_out, a);
        sample_in = b;
        n = 1;
        @(negedge clk);
        while (!busy && n < 100) begin n++; @(negedge clk); end
        check(n == ACQ_CYC, "R7 acquisition length", n, ACQ_CYC);
        sample_in = 16'hDEAD;
        check(bus_out == a, "R4 old result in auto conv", bus_out, a);
        count_busy(n);
        check(bus_out == b, "R7 auto capture", bus_out, b);
        check(n == CONV_CYC - 1, "R7 auto conv length", n + 1, CONV_CYC);
        // R8: release start in acquisition
        cnv_n = 1'b1;
        idle_cycles(ACQ_CYC + 4);
        check(busy == 1'b0, "R8 auto restart cancelled", busy, 0);
    endtask

    task automatic t_pd_beats_start;
        cnv_n = 1'b1;
        @(negedge clk);
        pwrdn = 1'b1;
        cnv_n = 1'b0;
        idle_cycles(3);
        check(busy == 1'b0, "R12 power-down wins", busy, 0);
        pwrdn = 1'b0;
        cnv_n = 1'b1;
        idle_cycles(2);
    endtask

    initial begin
        t_reset();
        t_basic(16'h1234, 16'h0000);
        t_coding_oe(16'h1234);
        t_basic(16'hF00F, 16'h1234);
        t_coding_oe(16'hF00F);
        t_extra_edges(16'h0A5A);
        t_powerdown(16'h7FFF);
        t_auto(16'h4321, 16'hBEEF);
        t_pd_beats_start();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule